// File: doc/BRIEF.md
# Pausable Timed Traffic Light Controller

This block sequences a single set of three lamps (red, green, yellow) through a fixed rotation. Each phase lasts a set number of clock cycles. The controller comes out of reset showing red. It moves to green, then to yellow, and back to red, and repeats this with no end.

A run input works as a freeze control. While it is low, the lamp stays where it is and the elapsed-cycle count for the current phase is kept. When run goes high again, the phase finishes only the cycles it still had left. The reset input clears the controller at once, without waiting for a clock. Its release passes through a two-stage synchronizer, so counting starts a fixed number of edges after release.

Top module: `tl_lamp_ctrl`

## Requirements
- R1: While rst_ni is low, red_o is 1 and yellow_o and green_o are 0, and this takes effect without a clock edge.
- R2: After rst_ni rises, the first two rising edges do not advance the controller; the third rising edge is the first that counts.
- R3: The red phase lasts exactly 32 counting edges with run_i high; on the 32nd such edge the lamp changes to green.
- R4: The green phase lasts exactly 20 counting edges with run_i high; on the 20th such edge the lamp changes to yellow.
- R5: The yellow phase lasts exactly 7 counting edges with run_i high; on the 7th such edge the lamp changes back to red, and the rotation repeats.
- R6: A rising edge with run_i low changes neither the lamp nor the elapsed count of the current phase, so a phase that is paused resumes with the count it had.
- R7: Exactly one of red_o, yellow_o and green_o is 1 in every cycle.
- R8: The lamp changes only in the order red to green, green to yellow, yellow to red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | High: phase time advances; low: phase and count are frozen |
| red_o | output | 1 | Red lamp drive |
| yellow_o | output | 1 | Yellow lamp drive |
| green_o | output | 1 | Green lamp drive |

## Verification
The hardest case to reach is a pause on the last cycle of a phase, when the counter is one step from expiry and a held run_i must still stop the lamp change. The stimulus counts enabled edges so it can drop run_i exactly there, in red and green, and again at count zero in yellow. After that it runs an irregular enable pattern across several rotations. A bench model tracks each phase and its count and predicts the lamp for every cycle. This gives exact dwell times. It also checks a reset that arrives in the middle of a phase and the two-edge delay after the reset is released.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    PH_RED    = 2'd0,
    PH_GREEN  = 2'd1,
    PH_YELLOW = 2'd2
  } phase_e;

  localparam int unsigned NUM_PHASES = 3;

  function automatic phase_e phase_succ(input phase_e cur);
    case (cur)
      PH_RED:    return PH_GREEN;
      PH_GREEN:  return PH_YELLOW;
      default:   return PH_RED;
    endcase
  endfunction

endpackage

// File: rtl/tl_rst_sync.sv
module tl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/tl_dwell_ctr.sv
module tl_dwell_ctr #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             expire;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (run_i) begin
      if (cnt_q == last_i) begin
        cnt_d  = '0;
        expire = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = expire;

  // R6
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);

endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
  import tl_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned RED_CYC = 32,
  parameter int unsigned GRN_CYC = 20,
  parameter int unsigned YEL_CYC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expire_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] last_o
);

  localparam logic [CNT_W-1:0] RED_LAST = CNT_W'(RED_CYC - 1);
  localparam logic [CNT_W-1:0] GRN_LAST = CNT_W'(GRN_CYC - 1);
  localparam logic [CNT_W-1:0] YEL_LAST = CNT_W'(YEL_CYC - 1);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (expire_i) begin
      phase_d = phase_succ(phase_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RED;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_comb begin
    case (phase_q)
      PH_RED:    last_o = RED_LAST;
      PH_GREEN:  last_o = GRN_LAST;
      default:   last_o = YEL_LAST;
    endcase
  end

  assign phase_o = phase_q;

  // R6
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_i |=> $stable(phase_q));

  // R8
  red_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RED) |=> (phase_q == PH_RED || phase_q == PH_GREEN));

  // R8
  green_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GREEN) |=> (phase_q == PH_GREEN || phase_q == PH_YELLOW));

  // R8
  yellow_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_YELLOW) |=> (phase_q == PH_YELLOW || phase_q == PH_RED));

endmodule

// File: rtl/tl_lamp_dec.sv
module tl_lamp_dec
  import tl_pkg::*;
(
  input  phase_e                  phase_i,
  output logic [NUM_PHASES-1:0]   lamp_o
);

  for (genvar gi = 0; gi < NUM_PHASES; gi++) begin : g_lamp
    assign lamp_o[gi] = (phase_i == phase_e'(gi));
  end

endmodule

// File: rtl/tl_lamp_ctrl.sv
module tl_lamp_ctrl
  import tl_pkg::*;
#(
  parameter int unsigned RED_CYC    = 32,
  parameter int unsigned GRN_CYC    = 20,
  parameter int unsigned YEL_CYC    = 7,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic red_o,
  output logic yellow_o,
  output logic green_o
);

  localparam int unsigned MAX_RG = (RED_CYC > GRN_CYC) ? RED_CYC : GRN_CYC;
  localparam int unsigned MAX_D  = (MAX_RG > YEL_CYC) ? MAX_RG : YEL_CYC;
  localparam int unsigned CNT_W  = (MAX_D > 2) ? $clog2(MAX_D) : 1;

  logic                  rst_int_n;
  logic                  expire;
  logic [CNT_W-1:0]      last;
  phase_e                phase;
  logic [NUM_PHASES-1:0] lamp;

  tl_rst_sync #(
    .STAGES (SYNC_STAGE)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  tl_dwell_ctr #(
    .CNT_W (CNT_W)
  ) u_dwell_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .run_i    (run_i),
    .last_i   (last),
    .expire_o (expire)
  );

  tl_phase_fsm #(
    .CNT_W   (CNT_W),
    .RED_CYC (RED_CYC),
    .GRN_CYC (GRN_CYC),
    .YEL_CYC (YEL_CYC)
  ) u_phase_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .expire_i (expire),
    .phase_o  (phase),
    .last_o   (last)
  );

  tl_lamp_dec u_lamp_dec (
    .phase_i (phase),
    .lamp_o  (lamp)
  );

  assign red_o    = lamp[PH_RED];
  assign green_o  = lamp[PH_GREEN];
  assign yellow_o = lamp[PH_YELLOW];

  // R7
  one_lamp_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $countones({red_o, yellow_o, green_o}) == 1);

  // R1
  reset_red_chk: assert property (@(posedge clk_i)
    !rst_int_n |-> red_o);

endmodule

// File: tb/tl_lamp_ctrl_tb.sv
module tl_lamp_ctrl_tb;

  typedef struct {
    int         cyc;
    logic [2:0] exp_ryg;
    string      req;
  } item_t;

  logic clk;
  logic rst_n;
  logic run;
  logic red, yellow, green;

  int    cyc;
  int    checks;
  int    errors;
  item_t sb_q[$];

  int m_sync;
  int m_phase;
  int m_cnt;

  tl_lamp_ctrl u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .run_i    (run),
    .red_o    (red),
    .yellow_o (yellow),
    .green_o  (green)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int dwell(input int ph);
    if (ph == 0) return 32;
    if (ph == 1) return 20;
    return 7;
  endfunction

  function automatic logic [2:0] lamp_of(input int ph);
    if (ph == 0) return 3'b100;
    if (ph == 1) return 3'b001;
    return 3'b010;
  endfunction

  function automatic string req_of(input int ph);
    if (ph == 0) return "R3";
    if (ph == 1) return "R4";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got ryg=%b expected ryg=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Driver: called at posedge+1; predicts the lamps after the next edge.
  task automatic step(input logic en);
    item_t it;
    string tag;
    run = en;
    if (m_sync < 2) begin
      m_sync++;
      tag = "R2";
    end else if (!en) begin
      tag = "R6";
    end else begin
      tag = req_of(m_phase);
      if (m_cnt == dwell(m_phase) - 1) begin
        m_cnt   = 0;
        m_phase = (m_phase + 1) % 3;
        tag     = {tag, "/R8"};
      end else begin
        m_cnt++;
      end
    end
    it.cyc     = cyc + 1;
    it.exp_ryg = lamp_of(m_phase);
    it.req     = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n, input logic en);
    for (int i = 0; i < n; i++) step(en);
  endtask

  // Monitor: compares outputs away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.req, {red, yellow, green}, it.exp_ryg);
        checks++;
        if ($countones({red, yellow, green}) != 1) begin
          errors++;
          $display("FAIL R7 got ryg=%b expected one lamp high", {red, yellow, green});
        end
      end
    end
  end

  task automatic reset_and_release();
    rst_n = 1'b0;
    #1;
    check("R1", {red, yellow, green}, 3'b100);
    m_sync = 0; m_phase = 0; m_cnt = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R1", {red, yellow, green}, 3'b100);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    run    = 1'b1;
    rst_n  = 1'b1;
    #2;
    reset_and_release();

    // sync release, then two full rotations with enable held high
    steps(2, 1'b1);
    steps(118, 1'b1);

    // pause on the last red cycle, then the edge that leaves red
    steps(31, 1'b1);
    steps(4, 1'b0);
    steps(1, 1'b1);
    // pause on the last green cycle
    steps(19, 1'b1);
    steps(3, 1'b0);
    steps(1, 1'b1);
    // pause at the first yellow count
    steps(2, 1'b0);
    steps(7, 1'b1);
    // pause in the middle of red
    steps(10, 1'b1);
    steps(5, 1'b0);
    steps(22, 1'b1);

    // irregular enable pattern over several rotations
    for (int i = 0; i < 200; i++) step((i % 3) != 0 && (i % 7) != 5);

    // asynchronous reset in the middle of a phase, run held high
    steps(40, 1'b1);
    reset_and_release();
    steps(2, 1'b1);
    steps(70, 1'b1);

    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule